// File: doc/BRIEF.md
# Network Controller Low-Power State Sequencer

This block decides when a network controller may be treated as suspended, and when it watches for a wake-up frame. The host writes a control word that holds a suspend request and two wake-mode bits. A request to suspend makes the block run an ordered drain. It asks the transmit engine to stop and write back its descriptors, and waits for that engine to report done. It then does the same with the receive engine. Only after both engines are done does the suspend status turn on. The host finds out that suspend has been reached by polling the control word.

The block also decides which host accesses are allowed on two register groups. One group is a pair of 4-bit ring-length copies that are loaded at initialisation. The other is a 16-bit multicast filter word. Both can be reached only while the controller is stopped or suspended. A read that is not allowed returns zero and raises an error pulse. The wake-mode output combines a mode bit, an enable bit and an external sleep pin. The sleep pin is synchronised inside the block. The transmit and receive engines are not part of this block; each one connects through a request level and a done pulse.

Top module: `lp_state_seq`

## Requirements
- R1: A host write to address 0 with bit 0 set, made while `stop_i` is 0 and the block is idle, raises `tx_drain_req_o` in the next cycle. When `stop_i` is 1 in the cycle of such a write, the write does nothing: no request is raised and bit 0 of address 0 still reads 0.
- R2: `tx_drain_req_o` stays high until a `tx_drain_done_i` pulse arrives. In the cycle after that pulse, `tx_drain_req_o` is low and `rx_drain_req_o` is high. A `rx_drain_done_i` pulse has no effect while the transmit drain is pending. The two requests are never high together.
- R3: Bit 0 of address 0 reads 0 and `susp_o` is 0 through both drain phases. Both become 1 in the cycle after `rx_drain_done_i` is seen while `rx_drain_req_o` is high.
- R4: A host write to address 0 with bit 0 clear ends suspend or any drain in progress. A `soft_rst_i` pulse, `stop_i` high or `rst_ni` low does the same, and clears both requests and `susp_o` by the next cycle. When `stop_i` is high in the same cycle as a suspend write, `stop_i` wins.
- R5: Leaving suspend by a host write keeps all stored state. The ring-length copies and the filter word hold their values, and a new suspend request can be made at once without loading anything again.
- R6: `mp_active_o` equals address-0 bit 1 AND (synchronised sleep pin OR address-0 bit 2). A change on `sleep_pin_i` reaches the output only after two clock edges.
- R7: Address-0 bits 1 and 2 can always be written and read back. `rst_ni` and `soft_rst_i` clear them. `stop_i` does not change them.
- R8: Address 1 reads the transmit ring-length copy in bits [3:0] and the receive copy in bits [7:4]. Both are loaded by `init_load_i`. Host writes to address 1 are ignored, and `soft_rst_i` and `stop_i` leave the copies unchanged.
- R9: Address 2 holds a 16-bit filter word in bits [15:0]. It can be written only while `stop_i` is 1 or the block is suspended; a write at any other time is dropped. Bits [31:16] always read 0.
- R10: A read of address 1 or 2 while `stop_i` is 0 and the block is not suspended returns 0 and sets `acc_err_o` for that one read-data cycle. Read data and the error flag appear in the cycle after `reg_re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| stop_i | input | 1 | Controller stop level |
| sleep_pin_i | input | 1 | Asynchronous external sleep pin |
| reg_we_i | input | 1 | Host write enable |
| reg_re_i | input | 1 | Host read enable |
| reg_addr_i | input | 2 | Host word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_re_i |
| acc_err_o | output | 1 | Disallowed-read pulse, aligned with read data |
| init_load_i | input | 1 | Load strobe for the ring-length copies |
| init_tx_len_i | input | 4 | Transmit ring-length code to load |
| init_rx_len_i | input | 4 | Receive ring-length code to load |
| tx_drain_req_o | output | 1 | Transmit drain request level |
| tx_drain_done_i | input | 1 | Transmit drain done pulse |
| rx_drain_req_o | output | 1 | Receive drain request level |
| rx_drain_done_i | input | 1 | Receive drain done pulse |
| susp_o | output | 1 | Suspend reached |
| mp_active_o | output | 1 | Wake-frame watch mode active |

## Verification
Two events can fall in the same cycle: a host suspend write and a stop or soft reset, and a drain-done pulse and an abort. The bench makes them meet by driving `stop_i` or `soft_rst_i` on the same clock edge as the control write, and also while a drain request is still open. The abort must win each time: no request is left high and the suspend bit reads 0. A done pulse that arrives for the wrong phase is also injected, and the bench checks that the current request is unchanged.

// File: rtl/lp_state_pkg.sv
package lp_state_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_TX_DRAIN = 2'd1,
    ST_RX_DRAIN = 2'd2,
    ST_SUSP     = 2'd3
  } drain_st_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_RLEN = 1;
  localparam int unsigned ADDR_FILT = 2;

  localparam int unsigned BIT_SUSP  = 0;
  localparam int unsigned BIT_MPMD  = 1;
  localparam int unsigned BIT_MPEN  = 2;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lp_drain_fsm.sv
module lp_drain_fsm
  import lp_state_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      stop_i,
  input  logic      susp_set_i,
  input  logic      susp_clr_i,
  input  logic      tx_done_i,
  input  logic      rx_done_i,
  output logic      tx_req_o,
  output logic      rx_req_o,
  output logic      suspended_o
);
  drain_st_e state_q, state_d;
  logic      abort;

  // stop, soft reset and a host clear all force idle
  assign abort = stop_i | soft_rst_i | susp_clr_i;

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (susp_set_i) state_d = ST_TX_DRAIN;
        ST_TX_DRAIN: if (tx_done_i)  state_d = ST_RX_DRAIN;
        ST_RX_DRAIN: if (rx_done_i)  state_d = ST_SUSP;
        ST_SUSP:     state_d = ST_SUSP;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign tx_req_o    = (state_q == ST_TX_DRAIN);
  assign rx_req_o    = (state_q == ST_RX_DRAIN);
  assign suspended_o = (state_q == ST_SUSP);
endmodule

// File: rtl/lp_reg_gate.sv
module lp_reg_gate
  import lp_state_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned FILT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              stop_i,
  input  logic              suspended_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              acc_err_o,
  input  logic              init_load_i,
  input  logic [LEN_W-1:0]  init_tx_len_i,
  input  logic [LEN_W-1:0]  init_rx_len_i,
  output logic              susp_set_o,
  output logic              susp_clr_o,
  output logic              mp_mode_o,
  output logic              mp_en_o
);
  localparam int unsigned RLEN_W = 2 * LEN_W;

  logic              sel_ctrl, sel_rlen, sel_filt, wr_ctrl, allow;
  logic              mp_mode_q, mp_en_q;
  logic [LEN_W-1:0]  tx_len_q, rx_len_q;
  logic [FILT_W-1:0] filt_q;
  logic [DATA_W-1:0] rd_d;
  logic              err_d;

  assign sel_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_rlen = (addr_i == ADDR_W'(ADDR_RLEN));
  assign sel_filt = (addr_i == ADDR_W'(ADDR_FILT));
  assign allow    = stop_i | suspended_i;
  assign wr_ctrl  = we_i & sel_ctrl;

  assign susp_set_o = wr_ctrl &  wdata_i[BIT_SUSP];
  assign susp_clr_o = wr_ctrl & ~wdata_i[BIT_SUSP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_mode_q <= 1'b0;
      mp_en_q   <= 1'b0;
    end else if (soft_rst_i) begin
      mp_mode_q <= 1'b0;
      mp_en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      mp_mode_q <= wdata_i[BIT_MPMD];
      mp_en_q   <= wdata_i[BIT_MPEN];
    end
  end

  // ring-length copies survive every reset; only init loads them
  always_ff @(posedge clk_i) begin
    if (init_load_i) begin
      tx_len_q <= init_tx_len_i;
      rx_len_q <= init_rx_len_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i && sel_filt && allow) filt_q <= wdata_i[FILT_W-1:0];
  end

  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    if (re_i) begin
      if (sel_ctrl) begin
        rd_d[BIT_SUSP] = suspended_i;
        rd_d[BIT_MPMD] = mp_mode_q;
        rd_d[BIT_MPEN] = mp_en_q;
      end else if (sel_rlen) begin
        if (allow) rd_d[RLEN_W-1:0] = {rx_len_q, tx_len_q};
        else       err_d = 1'b1;
      end else if (sel_filt) begin
        if (allow) rd_d[FILT_W-1:0] = filt_q;
        else       err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      acc_err_o <= 1'b0;
    end else begin
      rdata_o   <= rd_d;
      acc_err_o <= err_d;
    end
  end

  assign mp_mode_o = mp_mode_q;
  assign mp_en_o   = mp_en_q;
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned FILT_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              stop_i,
  input  logic              sleep_pin_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              acc_err_o,
  input  logic              init_load_i,
  input  logic [LEN_W-1:0]  init_tx_len_i,
  input  logic [LEN_W-1:0]  init_rx_len_i,
  output logic              tx_drain_req_o,
  input  logic              tx_drain_done_i,
  output logic              rx_drain_req_o,
  input  logic              rx_drain_done_i,
  output logic              susp_o,
  output logic              mp_active_o
);
  logic sleep_sync, suspended, susp_set, susp_clr, mp_mode, mp_en;

  lp_sync #(.STAGES(SYNC_STAGES)) u_sleep_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sleep_pin_i),
    .q_o    (sleep_sync)
  );

  lp_drain_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .stop_i      (stop_i),
    .susp_set_i  (susp_set),
    .susp_clr_i  (susp_clr),
    .tx_done_i   (tx_drain_done_i),
    .rx_done_i   (rx_drain_done_i),
    .tx_req_o    (tx_drain_req_o),
    .rx_req_o    (rx_drain_req_o),
    .suspended_o (suspended)
  );

  lp_reg_gate #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .FILT_W (FILT_W)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .stop_i        (stop_i),
    .suspended_i   (suspended),
    .we_i          (reg_we_i),
    .re_i          (reg_re_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .rdata_o       (reg_rdata_o),
    .acc_err_o     (acc_err_o),
    .init_load_i   (init_load_i),
    .init_tx_len_i (init_tx_len_i),
    .init_rx_len_i (init_rx_len_i),
    .susp_set_o    (susp_set),
    .susp_clr_o    (susp_clr),
    .mp_mode_o     (mp_mode),
    .mp_en_o       (mp_en)
  );

  assign susp_o      = suspended;
  assign mp_active_o = mp_mode & (sleep_sync | mp_en);
endmodule

// File: rtl/lp_state_seq_chk.sv
module lp_state_seq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              stop_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              acc_err_o,
  input logic              tx_drain_req_o,
  input logic              tx_drain_done_i,
  input logic              rx_drain_req_o,
  input logic              rx_drain_done_i,
  input logic              susp_o,
  input logic              mp_active_o,
  input logic              mp_mode
);
  a_r1_stop_blocks_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == '0 && reg_wdata_i[0] && stop_i &&
     !tx_drain_req_o && !rx_drain_req_o && !susp_o) |=> !tx_drain_req_o);

  a_r2_rx_follows_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_drain_req_o) |-> $past(tx_drain_req_o && tx_drain_done_i));

  a_r2_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_drain_req_o && rx_drain_req_o));

  a_r3_susp_after_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_o) |-> $past(rx_drain_req_o && rx_drain_done_i));

  a_r4_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || soft_rst_i) |=> (!susp_o && !tx_drain_req_o && !rx_drain_req_o));

  a_r6_mode_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp_active_o |-> mp_mode);

  a_r10_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (reg_rdata_o == '0));
endmodule

bind lp_state_seq lp_state_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .soft_rst_i      (soft_rst_i),
  .stop_i          (stop_i),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .acc_err_o       (acc_err_o),
  .tx_drain_req_o  (tx_drain_req_o),
  .tx_drain_done_i (tx_drain_done_i),
  .rx_drain_req_o  (rx_drain_req_o),
  .rx_drain_done_i (rx_drain_done_i),
  .susp_o          (susp_o),
  .mp_active_o     (mp_active_o),
  .mp_mode         (mp_mode)
);

// File: tb/lp_state_seq_bench.sv
module lp_state_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, stop = 1'b0, sleep_pin = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        acc_err;
  logic        init_load = 1'b0;
  logic [3:0]  init_tx = '0, init_rx = '0;
  logic        tx_req, tx_done = 1'b0, rx_req, rx_done = 1'b0;
  logic        susp, mp_act;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lp_state_seq u_lp_state_seq (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .soft_rst_i      (soft_rst),
    .stop_i          (stop),
    .sleep_pin_i     (sleep_pin),
    .reg_we_i        (we),
    .reg_re_i        (re),
    .reg_addr_i      (addr),
    .reg_wdata_i     (wdata),
    .reg_rdata_o     (rdata),
    .acc_err_o       (acc_err),
    .init_load_i     (init_load),
    .init_tx_len_i   (init_tx),
    .init_rx_len_i   (init_rx),
    .tx_drain_req_o  (tx_req),
    .tx_drain_done_i (tx_done),
    .rx_drain_req_o  (rx_req),
    .rx_drain_done_i (rx_done),
    .susp_o          (susp),
    .mp_active_o     (mp_act)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata; e = acc_err;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R4 reset tx_req", tx_req, 0);
    check("R4 reset rx_req", rx_req, 0);
    check("R4 reset susp", susp, 0);
    check("R7 reset mp_active", mp_act, 0);
    rd(2'd0, d, e);
    check("R7 reset ctrl read", d, 0);
  endtask

  task automatic t_gating();
    logic [31:0] d; logic e;
    @(negedge clk); init_load = 1'b1; init_tx = 4'h5; init_rx = 4'hA;
    @(negedge clk); init_load = 1'b0;
    rd(2'd1, d, e);
    check("R10 rlen blocked data", d, 0);
    check("R10 rlen blocked err", {31'd0, e}, 1);
    @(negedge clk); stop = 1'b1;
    wr(2'd2, 32'hFFFF_5678);
    rd(2'd2, d, e);
    check("R9 filter upper zero", d, 32'h0000_5678);
    check("R10 allowed read no err", {31'd0, e}, 0);
    wr(2'd1, 32'h0000_00FF);
    rd(2'd1, d, e);
    check("R8 rlen layout, write ignored", d, 32'h0000_00A5);
    @(negedge clk); stop = 1'b0;
    wr(2'd2, 32'h0000_1111);
    rd(2'd2, d, e);
    check("R10 filter blocked err", {31'd0, e}, 1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; stop = 1'b1;
    rd(2'd2, d, e);
    check("R9 blocked write dropped", d, 32'h0000_5678);
    rd(2'd1, d, e);
    check("R8 rlen kept over soft reset", d, 32'h0000_00A5);
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_stop_blocks();
    logic [31:0] d; logic e;
    @(negedge clk); stop = 1'b1;
    wr(2'd0, 32'h1);
    check("R1 no request under stop", tx_req, 0);
    rd(2'd0, d, e);
    check("R1 susp bit stays 0 under stop", d[0], 0);
    @(negedge clk); stop = 1'b0;
    // stop and write in the same cycle
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 32'h1; stop = 1'b1;
    @(negedge clk); we = 1'b0; stop = 1'b0;
    check("R4 stop beats same-cycle write", tx_req, 0);
  endtask

  task automatic t_order();
    logic [31:0] d; logic e;
    wr(2'd0, 32'h1);
    check("R1 tx request raised", tx_req, 1);
    check("R2 rx request low first", rx_req, 0);
    rd(2'd0, d, e);
    check("R3 susp bit 0 during tx drain", d[0], 0);
    pulse_rx();
    check("R2 early rx done ignored", {30'd0, tx_req, rx_req}, 32'h2);
    pulse_tx();
    check("R2 rx phase after tx done", {30'd0, tx_req, rx_req}, 32'h1);
    check("R3 susp still 0 in rx drain", susp, 0);
    pulse_tx();
    check("R2 tx done ignored in rx phase", {30'd0, tx_req, rx_req}, 32'h1);
    pulse_rx();
    check("R3 susp after rx done", susp, 1);
    check("R2 requests low when suspended", {30'd0, tx_req, rx_req}, 0);
    rd(2'd0, d, e);
    check("R3 susp bit reads 1", d[0], 1);
    rd(2'd1, d, e);
    check("R8 rlen readable in suspend", d, 32'h0000_00A5);
    wr(2'd2, 32'h0000_9ABC);
    wr(2'd0, 32'h0);
    check("R4 host clear leaves suspend", susp, 0);
    @(negedge clk); stop = 1'b1;
    rd(2'd2, d, e);
    check("R5 filter kept after resume", d, 32'h0000_9ABC);
    rd(2'd1, d, e);
    check("R5 rlen kept after resume", d, 32'h0000_00A5);
    @(negedge clk); stop = 1'b0;
    wr(2'd0, 32'h1);
    check("R5 re-suspend without init", tx_req, 1);
    wr(2'd0, 32'h0);
    check("R4 host clear aborts drain", tx_req, 0);
  endtask

  task automatic t_abort();
    wr(2'd0, 32'h1);
    pulse_tx();
    check("R2 in rx phase before abort", rx_req, 1);
    @(negedge clk); stop = 1'b1; rx_done = 1'b1;
    @(negedge clk); stop = 1'b0; rx_done = 1'b0;
    check("R4 stop beats rx done", {29'd0, tx_req, rx_req, susp}, 0);
    wr(2'd0, 32'h1);
    @(negedge clk); soft_rst = 1'b1; tx_done = 1'b1;
    @(negedge clk); soft_rst = 1'b0; tx_done = 1'b0;
    check("R4 soft reset aborts tx drain", {29'd0, tx_req, rx_req, susp}, 0);
    wr(2'd0, 32'h1);
    pulse_tx();
    pulse_rx();
    check("R3 suspended before stop", susp, 1);
    @(negedge clk); stop = 1'b1;
    @(negedge clk);
    check("R4 stop leaves suspend", susp, 0);
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_magic();
    logic [31:0] d; logic e;
    wr(2'd0, 32'h2);
    check("R6 mode only, no wake source", mp_act, 0);
    @(negedge clk); sleep_pin = 1'b1;
    @(negedge clk);
    check("R6 pin not yet through sync", mp_act, 0);
    @(negedge clk);
    check("R6 pin after two edges", mp_act, 1);
    @(negedge clk); sleep_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 pin released", mp_act, 0);
    wr(2'd0, 32'h6);
    check("R6 enable bit activates", mp_act, 1);
    wr(2'd0, 32'h4);
    check("R6 no mode, enable alone", mp_act, 0);
    @(negedge clk); stop = 1'b1;
    wr(2'd0, 32'h6);
    rd(2'd0, d, e);
    check("R7 writable under stop", d, 32'h6);
    check("R7 stop keeps mode", mp_act, 1);
    @(negedge clk); stop = 1'b0;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(2'd0, d, e);
    check("R7 soft reset clears bits", d, 0);
    wr(2'd0, 32'h6);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R7 hard reset clears mode", mp_act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_stop_blocks();
    t_order();
    t_abort();
    t_magic();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule